// File: doc/BRIEF.md
# UART Transmit Buffer with Status Flags

This block is the send half of a register-mapped serial port. Software writes a character to the data address. The character lands in a single-entry holding register. Whenever the transmitter is enabled and its shifter has nothing to send, the held character moves into the shifter. The shifter then drives it onto the serial line as an asynchronous frame: a low start bit, 5 to 9 data bits sent least significant bit first, and one or two high stop bits. Each bit lasts 16 pulses of an external baud tick.

Two status flags tell software what to do next. The buffer-empty flag says another character may be written. The transmit-complete flag says the line has gone quiet with nothing pending. Each flag drives its own interrupt request, and each request has its own enable input. The complete flag is sticky. It is cleared by an interrupt acknowledge or by writing a one to bit 0 of the control address.

Top module: `uart_tx_buffer`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_done` is 0 and both interrupt requests are 0.
- R2: A write to the data address (`wr_addr` = 0) while `buf_empty` is 0 is discarded: the held character is unchanged and no extra frame is sent.
- R3: When `tx_enable` is 1, the shifter is idle and the holding register is full, the character moves to the shifter on the next clock edge. `buf_empty` returns to 1 and the start bit begins in that same cycle.
- R4: A frame is one low start bit, then the data bits least significant bit first, then the stop bits at 1. Every bit lasts 16 `baud_tick` pulses.
- R5: `char_size` picks the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8, 4 gives 9, and 5 to 7 give 8. Data bits above that count are not sent.
- R6: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. The size and stop settings are captured when a character enters the shifter.
- R7: `tx_done` sets only at the end of a frame's last stop bit, and only if the holding register is empty at that moment. It never sets while a further character waits.
- R8: `tx_done` clears on a one-cycle `done_ack`, or on a write to the control address (`wr_addr` = 1) with `wr_data[0]` = 1.
- R9: `irq_empty` equals `ie_empty` AND `buf_empty`. `irq_done` equals `ie_done` AND `tx_done`.
- R10: While `tx_enable` is 0, `txd` stays 1 from the next cycle, any frame in progress is abandoned, and a held character stays in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = data register, 1 = control register |
| wr_data | input | 9 | Write data |
| tx_enable | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One pulse per 1/16 of a bit time |
| char_size | input | 3 | Character size code |
| two_stop | input | 1 | Selects two stop bits |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_done | input | 1 | Enable for the transmit-complete interrupt |
| done_ack | input | 1 | Interrupt acknowledge for transmit complete |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
Frames are sent in four size and stop combinations, with data patterns that make a bit-order or bit-count error visible. One of them has zeros in the low bits and ones above the character size, so that sending stray upper bits would show. A burst of three writes in a row fills the shifter and the holding register and then hits a full register: the scoreboard must see exactly two frames, and the complete flag must stay low across the gap between them. Transmitting with the enable off, and clearing the flag both by acknowledge and by a register write, separate the gating and clearing paths.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned CHAR_W = 9;
    localparam int unsigned BITCNT_W = $clog2(CHAR_W + 1);

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    // Number of data bits selected by the size code
    function automatic logic [BITCNT_W-1:0] size_to_bits(input logic [2:0] code);
        case (code)
            3'd0:    return BITCNT_W'(5);
            3'd1:    return BITCNT_W'(6);
            3'd2:    return BITCNT_W'(7);
            3'd4:    return BITCNT_W'(9);
            default: return BITCNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int unsigned DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end else if (wr_req && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full = hold_q.full;
    assign data = hold_q.data;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int unsigned DW  = 9,
    parameter int unsigned TPB = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic                load,
    input  logic [DW-1:0]       load_data,
    input  logic [BITCNT_W-1:0] nbits,
    input  logic                two_stop,
    output logic                idle,
    output logic                txd,
    output logic                frame_end
);

    localparam int unsigned TW = (TPB > 1) ? $clog2(TPB) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TPB - 1);

    typedef struct packed {
        tx_state_e           st;
        logic [DW-1:0]       sh;
        logic [TW-1:0]       tcnt;
        logic [BITCNT_W-1:0] bcnt;
        logic [BITCNT_W-1:0] nb;
        logic                two;
        logic                fend;
    } shift_t;

    shift_t sh_d, sh_q;
    logic [DW-1:0] mask;
    logic bit_end;

    // Only the selected number of low bits survive into the shifter
    always_comb begin
        for (int i = 0; i < int'(DW); i++) begin
            mask[i] = (i < int'(nbits));
        end
    end

    assign bit_end = tick && (sh_q.tcnt == TICK_LAST);

    always_comb begin
        sh_d      = sh_q;
        sh_d.fend = 1'b0;
        if (!enable) begin
            sh_d.st   = ST_IDLE;
            sh_d.tcnt = '0;
            sh_d.bcnt = '0;
        end else begin
            if (tick) begin
                sh_d.tcnt = bit_end ? '0 : sh_q.tcnt + 1'b1;
            end
            case (sh_q.st)
                ST_IDLE: begin
                    sh_d.tcnt = '0;
                    if (load) begin
                        sh_d.st   = ST_START;
                        sh_d.sh   = load_data & mask;
                        sh_d.nb   = nbits;
                        sh_d.two  = two_stop;
                        sh_d.bcnt = '0;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        sh_d.st = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        sh_d.sh = sh_q.sh >> 1;
                        if (sh_q.bcnt == BITCNT_W'(sh_q.nb - 1'b1)) begin
                            sh_d.st   = ST_STOP;
                            sh_d.bcnt = '0;
                        end else begin
                            sh_d.bcnt = sh_q.bcnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (sh_q.two && (sh_q.bcnt == '0)) begin
                            sh_d.bcnt = BITCNT_W'(1);
                        end else begin
                            sh_d.st   = ST_IDLE;
                            sh_d.fend = 1'b1;
                        end
                    end
                end
                default: sh_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sh_q.st <= ST_IDLE;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign idle      = (sh_q.st == ST_IDLE);
    assign frame_end = sh_q.fend;
    assign txd       = (sh_q.st == ST_START) ? 1'b0 :
                       (sh_q.st == ST_DATA)  ? sh_q.sh[0] : 1'b1;

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic hold_full,
    input  logic clr_wr,
    input  logic ack,
    input  logic ie_empty,
    input  logic ie_done,
    output logic done,
    output logic irq_empty,
    output logic irq_done
);

    typedef struct packed {
        logic done;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (frame_end && !hold_full) begin
            fl_d.done = 1'b1;
        end else if (clr_wr || ack) begin
            fl_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign done      = fl_q.done;
    assign irq_empty = ie_empty && !hold_full;
    assign irq_done  = ie_done && fl_q.done;

endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer
    import uart_tx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              baud_tick,
    input  logic [2:0]        char_size,
    input  logic              two_stop,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              done_ack,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);

    logic              wr_req;
    logic              clr_wr;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              shift_idle;
    logic              load;
    logic              frame_end;

    assign wr_req = wr_en && (wr_addr == ADDR_DATA);
    assign clr_wr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];
    assign load   = tx_enable && shift_idle && hold_full;

    uart_tx_hold #(
        .DW(CHAR_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_shift #(
        .DW  (CHAR_W),
        .TPB (TICKS_PER_BIT)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_enable),
        .tick      (baud_tick),
        .load      (load),
        .load_data (hold_data),
        .nbits     (size_to_bits(char_size)),
        .two_stop  (two_stop),
        .idle      (shift_idle),
        .txd       (txd),
        .frame_end (frame_end)
    );

    uart_tx_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .hold_full (hold_full),
        .clr_wr    (clr_wr),
        .ack       (done_ack),
        .ie_empty  (ie_empty),
        .ie_done   (ie_done),
        .done      (tx_done),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    assign buf_empty = !hold_full;

endmodule

// File: rtl/uart_tx_buffer_chk.sv
module uart_tx_buffer_chk
    import uart_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic              tx_enable,
    input logic              txd,
    input logic              buf_empty,
    input logic              tx_done,
    input logic [CHAR_W-1:0] hold_data,
    input logic              shift_idle
);

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && wr_en && (wr_addr == ADDR_DATA)) |=> $stable(hold_data)); // R2

    AST_LOAD_FREES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && tx_enable && shift_idle) |=> (buf_empty && !shift_idle)); // R3

    AST_DONE_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(buf_empty)); // R7

    AST_DISABLED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> txd); // R10

    AST_DISABLED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !buf_empty) |=> !buf_empty); // R10

endmodule

bind uart_tx_buffer uart_tx_buffer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .tx_enable  (tx_enable),
    .txd        (txd),
    .buf_empty  (buf_empty),
    .tx_done    (tx_done),
    .hold_data  (hold_data),
    .shift_idle (shift_idle)
);

// File: tb/test_uart_tx_buffer.sv
module test_uart_tx_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_enable = 1'b0;
    logic       baud_tick = 1'b0;
    logic [2:0] char_size = 3'd3;
    logic       two_stop = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_done = 1'b0;
    logic       done_ack = 1'b0;
    logic       txd, buf_empty, tx_done, irq_empty, irq_done;

    int n_checks = 0;
    int n_fail = 0;
    int frames_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [8:0] d;
        int         nb;
        int         ns;
    } frame_t;

    frame_t exp_q[$];

    always #2 clk = ~clk;

    uart_tx_buffer i_uart_tx_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tx_enable (tx_enable),
        .baud_tick (baud_tick),
        .char_size (char_size),
        .two_stop  (two_stop),
        .ie_empty  (ie_empty),
        .ie_done   (ie_done),
        .done_ack  (done_ack),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tx_done   (tx_done),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    // baud tick: one pulse every second clock, so a bit is 32 clocks
    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic int bits_for(input logic [2:0] code);
        if (code <= 3'd2) return 5 + int'(code);
        if (code == 3'd4) return 9;
        return 8;
    endfunction

    // driver: pushes the expected frame when it should be accepted
    task automatic wr(input logic addr, input logic [8:0] d, input bit expect_frame);
        if (expect_frame) begin
            frame_t f;
            f.d  = d;
            f.nb = bits_for(char_size);
            f.ns = two_stop ? 2 : 1;
            exp_q.push_back(f);
        end
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tx_done) break;
        end
    endtask

    // monitor: samples each bit in its middle and compares to the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                frame_t f;
                logic [8:0] got;
                logic stops_ok;
                repeat (15) @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R2/R4: unexpected frame, got start %b expected no frame", txd);
                    repeat (400) @(negedge clk);
                end else begin
                    f = exp_q.pop_front();
                    got = '0;
                    stops_ok = 1'b1;
                    check("R4 start bit", txd, 1'b0);
                    for (int b = 0; b < f.nb; b++) begin
                        repeat (32) @(negedge clk);
                        got[b] = txd;
                    end
                    for (int s = 0; s < f.ns; s++) begin
                        repeat (32) @(negedge clk);
                        if (txd !== 1'b1) stops_ok = 1'b0;
                    end
                    n_checks++;
                    frames_seen++;
                    if (got !== (f.d & 9'((1 << f.nb) - 1)) || !stops_ok) begin
                        n_fail++;
                        $display("FAIL R4/R5/R6: data %h stops_ok %b expected %h with %0d stops",
                                 got, stops_ok, f.d & 9'((1 << f.nb) - 1), f.ns);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", txd, 1'b1);
        check("R1 buf_empty", buf_empty, 1'b1);
        check("R1 tx_done", tx_done, 1'b0);
        check("R1 irq_empty", irq_empty, 1'b0);
        check("R1 irq_done", irq_done, 1'b0);
        ie_empty = 1'b1;
        @(negedge clk);
        check("R9 irq_empty enabled", irq_empty, 1'b1);

        // 8 bits, one stop
        tx_enable = 1'b1;
        char_size = 3'd3;
        two_stop  = 1'b0;
        wr(1'b0, 9'h0A5, 1'b1);
        check("R3 held before load", buf_empty, 1'b0);
        check("R9 irq_empty follows full", irq_empty, 1'b0);
        @(negedge clk);
        check("R3 empty after load", buf_empty, 1'b1);
        check("R3 start begins", txd, 1'b0);
        check("R7 no done mid frame", tx_done, 1'b0);
        wait_done();
        check("R7 done after frame", tx_done, 1'b1);
        check("R9 irq_done gated off", irq_done, 1'b0);
        ie_done = 1'b1;
        @(negedge clk);
        check("R9 irq_done enabled", irq_done, 1'b1);
        wr(1'b1, 9'h000, 1'b0);
        check("R8 write zero keeps done", tx_done, 1'b1);
        wr(1'b1, 9'h001, 1'b0);
        check("R8 write one clears", tx_done, 1'b0);

        // burst: shifter busy, one held, one dropped
        wr(1'b0, 9'h03C, 1'b1);
        wr(1'b0, 9'h0C3, 1'b1);
        check("R2 second held", buf_empty, 1'b0);
        wr(1'b0, 9'h055, 1'b0);
        check("R2 still full", buf_empty, 1'b0);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (buf_empty) break;
        end
        repeat (5) @(negedge clk);
        check("R7 no done with char waiting", tx_done, 1'b0);
        wait_done();
        check("R7 done after burst", tx_done, 1'b1);
        repeat (600) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0 || frames_seen != 3) begin
            n_fail++;
            $display("FAIL R2: frames %0d pending %0d expected 3 and 0", frames_seen, exp_q.size());
        end
        @(negedge clk);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        check("R8 ack clears", tx_done, 1'b0);

        // 5 bits, upper bits set
        char_size = 3'd0;
        wr(1'b0, 9'h1E0, 1'b1);
        wait_done();
        wr(1'b1, 9'h001, 1'b0);
        // 7 bits, two stops
        char_size = 3'd2;
        two_stop  = 1'b1;
        wr(1'b0, 9'h12B, 1'b1);
        wait_done();
        wr(1'b1, 9'h001, 1'b0);
        // 9 bits, two stops
        char_size = 3'd4;
        wr(1'b0, 9'h15A, 1'b1);
        wait_done();
        wr(1'b1, 9'h001, 1'b0);
        // code 6 falls back to 8 bits, one stop
        char_size = 3'd6;
        two_stop  = 1'b0;
        wr(1'b0, 9'h1B4, 1'b1);
        wait_done();
        wr(1'b1, 9'h001, 1'b0);

        // R10 disabled transmitter holds the character
        tx_enable = 1'b0;
        char_size = 3'd3;
        wr(1'b0, 9'h096, 1'b1);
        repeat (100) @(negedge clk);
        check("R10 char held while disabled", buf_empty, 1'b0);
        check("R10 line high while disabled", txd, 1'b1);
        check("R10 no done while disabled", tx_done, 1'b0);
        tx_enable = 1'b1;
        wait_done();
        check("R10 sent after enable", tx_done, 1'b1);
        repeat (100) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0 || frames_seen != 8) begin
            n_fail++;
            $display("FAIL R4: frames %0d pending %0d expected 8 and 0", frames_seen, exp_q.size());
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule